// File: doc/BRIEF.md
# Load and Store Buffer Unit

This block holds memory operations that have been issued but not finished, treating them like functional units. A load takes a free load slot and asks memory for data. Memory may answer after one cycle or many, so several loads can be in flight and can finish in any order. When a load's data comes back, the slot offers data and its own tag on the result broadcast. When the broadcast is granted, the slot is freed.

A store takes a slot in a small in-order store queue. It holds the target address and either the value to write or the tag of the unit that will produce that value. A waiting store watches the broadcast bus. It takes the value when a broadcast carries its producer tag. Once it has data and is the oldest store, it writes memory and leaves the queue on the write acknowledge. A load whose address matches a store that is already queued waits until that store has written memory.

Load slot states and transitions:
- `LD_FREE`→`LD_HOLD` on allocation with a conflicting store, or `LD_FREE`→`LD_REQ` on allocation without one.
- `LD_HOLD`→`LD_REQ` when every conflicting store has retired.
- `LD_REQ`→`LD_WAIT` when memory accepts the read.
- `LD_WAIT`→`LD_DONE` on a response carrying the slot index.
- `LD_DONE`→`LD_FREE` on broadcast grant.

Store entry states and transitions:
- `ST_FREE`→`ST_WDATA` on allocation with a pending producer, or `ST_FREE`→`ST_READY` on allocation with data present.
- `ST_WDATA`→`ST_READY` on a broadcast whose tag matches.
- `ST_READY`→`ST_WACK` when the head write is accepted.
- `ST_WACK`→`ST_FREE` on write acknowledge.

Top module: `mem_buffer_unit`

## Requirements
- R1: After reset all slots are free: `ld_req_ready` and `st_req_ready` are 1, and `mem_req_valid` and `res_valid` are 0.
- R2: A new load takes the lowest-numbered free load slot `i`. `ld_issue_tag` shows `i+1` (tag 0 means "no producer"). The load's read goes out with `mem_req_id = i`. The response data is broadcast with `res_tag = i+1`, and the slot is freed on `res_grant`.
- R3: Loads complete out of order: a later load with a short memory latency broadcasts before an earlier load with a long latency.
- R4: With all 6 load slots busy, `ld_req_ready` is 0 and a load request is ignored.
- R5: A store issued with `st_req_qtag = 0` writes its data to its address and frees its entry on `mem_wr_ack`.
- R6: A store issued with a nonzero producer tag makes no memory write until a broadcast arrives with `snoop_tag` equal to that tag. It then writes the broadcast data.
- R7: A broadcast whose tag differs from a waiting store's producer tag does not change that store.
- R8: A load whose address equals that of an already queued store sends no read until that store's write is acknowledged, and then returns the stored value. A load to another address is not held.
- R9: With 3 stores queued, `st_req_ready` is 0.
- R10: Stores write memory one at a time in issue order. A younger store whose data is ready waits behind an older one that is not. When a store write and a load read compete, the store write takes the memory port.
- R11: A store issued in the same cycle as a broadcast that matches its producer tag takes that broadcast's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_req_valid | input | 1 | Load issue request |
| ld_req_addr | input | AW | Load effective address |
| ld_req_ready | output | 1 | A load slot is free |
| ld_issue_tag | output | TW | Tag the next load will receive |
| st_req_valid | input | 1 | Store issue request |
| st_req_addr | input | AW | Store target address |
| st_req_data | input | DW | Store value when the producer tag is 0 |
| st_req_qtag | input | TW | Producer tag of store data, 0 = value present |
| st_req_ready | output | 1 | A store entry is free |
| snoop_valid | input | 1 | Result broadcast valid |
| snoop_tag | input | TW | Result broadcast source tag |
| snoop_data | input | DW | Result broadcast data |
| res_valid | output | 1 | Load result offered for broadcast |
| res_tag | output | TW | Tag of offered load result |
| res_data | output | DW | Data of offered load result |
| res_grant | input | 1 | Broadcast bus granted to this unit |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Memory address |
| mem_req_wdata | output | DW | Write data |
| mem_req_id | output | LIW | Load slot index of a read |
| mem_rsp_valid | input | 1 | Read response |
| mem_rsp_id | input | LIW | Load slot index of response |
| mem_rsp_data | input | DW | Read data |
| mem_wr_ack | input | 1 | Write acknowledge |

## Verification
The bench mixes 1-cycle and 8-cycle memory latencies. A design that served loads strictly in order would broadcast the slow load first or put the wrong tag on the data.

The bench holds loads behind queued stores to the same address. A missing hold returns the stale memory value.

Waiting stores are fed mismatching tags, matching tags in the same cycle as issue, and a ready store queued behind a blocked one. A faulty design would write early, drop the same-cycle data, or write out of order, leaving the wrong final value at a shared address.

// File: rtl/mbu_pkg.sv
package mbu_pkg;
    typedef enum logic [2:0] {
        LD_FREE, LD_HOLD, LD_REQ, LD_WAIT, LD_DONE
    } ld_state_e;

    typedef enum logic [1:0] {
        ST_FREE, ST_WDATA, ST_READY, ST_WACK
    } st_state_e;
endpackage

// File: rtl/mbu_ld_slot.sv
module mbu_ld_slot
    import mbu_pkg::*;
#(
    parameter int N_ST = 3,
    parameter int AW   = 16,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc,
    input  logic [AW-1:0]   alloc_addr,
    input  logic [N_ST-1:0] alloc_dep,
    input  logic [N_ST-1:0] st_retire,
    input  logic            mem_grant,
    input  logic            rsp_hit,
    input  logic [DW-1:0]   rsp_data,
    input  logic            bc_grant,
    output logic            busy,
    output logic            want_mem,
    output logic            want_bc,
    output logic [AW-1:0]   addr_q,
    output logic [DW-1:0]   data_q
);
    ld_state_e       state, state_n;
    logic [N_ST-1:0] dep_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= LD_FREE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            LD_FREE: if (alloc) state_n = (alloc_dep == '0) ? LD_REQ : LD_HOLD;
            LD_HOLD: if ((dep_q & ~st_retire) == '0) state_n = LD_REQ;
            LD_REQ:  if (mem_grant) state_n = LD_WAIT;
            LD_WAIT: if (rsp_hit) state_n = LD_DONE;
            LD_DONE: if (bc_grant) state_n = LD_FREE;
            default: state_n = LD_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dep_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (alloc && state == LD_FREE) begin
                addr_q <= alloc_addr;
                dep_q  <= alloc_dep;
            end else begin
                dep_q <= dep_q & ~st_retire;
            end
            if (rsp_hit && state == LD_WAIT) data_q <= rsp_data;
        end
    end

    always_comb begin
        busy     = (state != LD_FREE);
        want_mem = (state == LD_REQ);
        want_bc  = (state == LD_DONE);
    end
endmodule

// File: rtl/mbu_st_queue.sv
module mbu_st_queue
    import mbu_pkg::*;
#(
    parameter int N_ST = 3,
    parameter int AW   = 16,
    parameter int DW   = 32,
    parameter int TW   = 4,
    localparam int SIW = (N_ST > 1) ? $clog2(N_ST) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc,
    input  logic [AW-1:0]   in_addr,
    input  logic [DW-1:0]   in_data,
    input  logic [TW-1:0]   in_qtag,
    input  logic            snoop_valid,
    input  logic [TW-1:0]   snoop_tag,
    input  logic [DW-1:0]   snoop_data,
    input  logic            wr_grant,
    input  logic            wr_ack,
    output logic            full,
    output logic [SIW-1:0]  tail,
    output logic [SIW:0]    count,
    output logic [N_ST-1:0] valid_vec,
    output logic [AW-1:0]   addr_arr [N_ST],
    output logic [N_ST-1:0] retire,
    output logic            want_write,
    output logic [AW-1:0]   wr_addr,
    output logic [DW-1:0]   wr_data,
    output logic [TW-1:0]   head_tag
);
    logic [SIW-1:0] head;
    st_state_e      state_arr [N_ST];
    logic [DW-1:0]  data_arr  [N_ST];
    logic [TW-1:0]  tag_arr   [N_ST];
    logic           in_hit, in_ready, do_retire;

    function automatic logic [SIW-1:0] bump(input logic [SIW-1:0] p);
        return (p == SIW'(N_ST - 1)) ? '0 : p + 1'b1;
    endfunction

    assign in_hit    = snoop_valid && (in_qtag != '0) && (snoop_tag == in_qtag);
    assign in_ready  = (in_qtag == '0) || in_hit;
    assign do_retire = wr_ack && (state_arr[head] == ST_WACK);

    for (genvar g = 0; g < N_ST; g++) begin : g_ent
        st_state_e     st, st_n;
        logic [AW-1:0] a_q;
        logic [DW-1:0] d_q;
        logic [TW-1:0] t_q;
        logic          mine_alloc, mine_head, snoop_hit;

        assign mine_alloc = alloc && (tail == SIW'(g));
        assign mine_head  = (head == SIW'(g));
        assign snoop_hit  = snoop_valid && (st == ST_WDATA) && (snoop_tag == t_q);

        always_ff @(posedge clk) begin
            if (!rst_n) st <= ST_FREE;
            else        st <= st_n;
        end

        always_comb begin
            st_n = st;
            unique case (st)
                ST_FREE:  if (mine_alloc) st_n = in_ready ? ST_READY : ST_WDATA;
                ST_WDATA: if (snoop_hit) st_n = ST_READY;
                ST_READY: if (wr_grant && mine_head) st_n = ST_WACK;
                ST_WACK:  if (wr_ack && mine_head) st_n = ST_FREE;
                default:  st_n = ST_FREE;
            endcase
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a_q <= '0;
                d_q <= '0;
                t_q <= '0;
            end else if (mine_alloc && st == ST_FREE) begin
                a_q <= in_addr;
                d_q <= in_hit ? snoop_data : in_data;
                t_q <= in_hit ? '0 : in_qtag;
            end else if (snoop_hit) begin
                d_q <= snoop_data;
                t_q <= '0;
            end
        end

        assign state_arr[g] = st;
        assign addr_arr[g]  = a_q;
        assign data_arr[g]  = d_q;
        assign tag_arr[g]   = t_q;
        assign valid_vec[g] = (st != ST_FREE);
        assign retire[g]    = do_retire && mine_head;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (alloc) tail <= bump(tail);
            if (do_retire) head <= bump(head);
            count <= count + (SIW+1)'(alloc) - (SIW+1)'(do_retire);
        end
    end

    always_comb begin
        full       = (count == (SIW+1)'(N_ST));
        want_write = (state_arr[head] == ST_READY);
        wr_addr    = addr_arr[head];
        wr_data    = data_arr[head];
        head_tag   = tag_arr[head];
    end
endmodule

// File: rtl/mem_buffer_unit.sv
module mem_buffer_unit
    import mbu_pkg::*;
#(
    parameter int N_LD = 6,
    parameter int N_ST = 3,
    parameter int AW   = 16,
    parameter int DW   = 32,
    parameter int TW   = 4,
    localparam int LIW = (N_LD > 1) ? $clog2(N_LD) : 1,
    localparam int SIW = (N_ST > 1) ? $clog2(N_ST) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld_req_valid,
    input  logic [AW-1:0]  ld_req_addr,
    output logic           ld_req_ready,
    output logic [TW-1:0]  ld_issue_tag,
    input  logic           st_req_valid,
    input  logic [AW-1:0]  st_req_addr,
    input  logic [DW-1:0]  st_req_data,
    input  logic [TW-1:0]  st_req_qtag,
    output logic           st_req_ready,
    input  logic           snoop_valid,
    input  logic [TW-1:0]  snoop_tag,
    input  logic [DW-1:0]  snoop_data,
    output logic           res_valid,
    output logic [TW-1:0]  res_tag,
    output logic [DW-1:0]  res_data,
    input  logic           res_grant,
    output logic           mem_req_valid,
    input  logic           mem_req_ready,
    output logic           mem_req_write,
    output logic [AW-1:0]  mem_req_addr,
    output logic [DW-1:0]  mem_req_wdata,
    output logic [LIW-1:0] mem_req_id,
    input  logic           mem_rsp_valid,
    input  logic [LIW-1:0] mem_rsp_id,
    input  logic [DW-1:0]  mem_rsp_data,
    input  logic           mem_wr_ack
);
    logic [N_LD-1:0] ld_busy, ld_want_mem, ld_want_bc, ld_alloc, ld_mgrant, ld_bgrant;
    logic [AW-1:0]   ld_addr [N_LD];
    logic [DW-1:0]   ld_data [N_LD];
    logic [LIW-1:0]  free_idx, mem_sel, bc_sel;
    logic            any_free, any_mem, any_bc;

    logic            st_full, st_alloc, st_want_write, st_wgrant;
    logic [SIW-1:0]  st_tail;
    logic [SIW:0]    st_count;
    logic [N_ST-1:0] st_valid, st_retire, ld_dep;
    logic [AW-1:0]   st_addr [N_ST];
    logic [AW-1:0]   st_wr_addr;
    logic [DW-1:0]   st_wr_data;
    logic [TW-1:0]   st_head_tag;

    always_comb begin
        any_free = 1'b0; free_idx = '0;
        any_mem  = 1'b0; mem_sel  = '0;
        any_bc   = 1'b0; bc_sel   = '0;
        for (int i = N_LD - 1; i >= 0; i--) begin
            if (!ld_busy[i])    begin any_free = 1'b1; free_idx = LIW'(i); end
            if (ld_want_mem[i]) begin any_mem  = 1'b1; mem_sel  = LIW'(i); end
            if (ld_want_bc[i])  begin any_bc   = 1'b1; bc_sel   = LIW'(i); end
        end
    end

    assign ld_req_ready = any_free;
    assign ld_issue_tag = TW'(free_idx) + TW'(1);
    assign st_req_ready = !st_full;
    assign st_alloc     = st_req_valid && !st_full;
    assign st_wgrant    = st_want_write && mem_req_ready;

    always_comb begin
        for (int j = 0; j < N_ST; j++) begin
            ld_dep[j] = (st_valid[j] && !st_retire[j] && st_addr[j] == ld_req_addr) ||
                        (st_alloc && st_tail == SIW'(j) && st_req_addr == ld_req_addr);
        end
    end

    for (genvar i = 0; i < N_LD; i++) begin : g_ld
        assign ld_alloc[i]  = ld_req_valid && any_free && (free_idx == LIW'(i));
        assign ld_mgrant[i] = !st_want_write && any_mem && (mem_sel == LIW'(i)) && mem_req_ready;
        assign ld_bgrant[i] = res_grant && any_bc && (bc_sel == LIW'(i));

        mbu_ld_slot #(.N_ST(N_ST), .AW(AW), .DW(DW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc     (ld_alloc[i]),
            .alloc_addr(ld_req_addr),
            .alloc_dep (ld_dep),
            .st_retire (st_retire),
            .mem_grant (ld_mgrant[i]),
            .rsp_hit   (mem_rsp_valid && mem_rsp_id == LIW'(i)),
            .rsp_data  (mem_rsp_data),
            .bc_grant  (ld_bgrant[i]),
            .busy      (ld_busy[i]),
            .want_mem  (ld_want_mem[i]),
            .want_bc   (ld_want_bc[i]),
            .addr_q    (ld_addr[i]),
            .data_q    (ld_data[i])
        );
    end

    mbu_st_queue #(.N_ST(N_ST), .AW(AW), .DW(DW), .TW(TW)) u_stq (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc      (st_alloc),
        .in_addr    (st_req_addr),
        .in_data    (st_req_data),
        .in_qtag    (st_req_qtag),
        .snoop_valid(snoop_valid),
        .snoop_tag  (snoop_tag),
        .snoop_data (snoop_data),
        .wr_grant   (st_wgrant),
        .wr_ack     (mem_wr_ack),
        .full       (st_full),
        .tail       (st_tail),
        .count      (st_count),
        .valid_vec  (st_valid),
        .addr_arr   (st_addr),
        .retire     (st_retire),
        .want_write (st_want_write),
        .wr_addr    (st_wr_addr),
        .wr_data    (st_wr_data),
        .head_tag   (st_head_tag)
    );

    always_comb begin
        mem_req_valid = st_want_write || any_mem;
        mem_req_write = st_want_write;
        mem_req_addr  = st_want_write ? st_wr_addr : ld_addr[mem_sel];
        mem_req_wdata = st_wr_data;
        mem_req_id    = st_want_write ? '0 : mem_sel;
        res_valid     = any_bc;
        res_tag       = TW'(bc_sel) + TW'(1);
        res_data      = ld_data[bc_sel];
    end
endmodule

// File: rtl/mbu_checker.sv
module mbu_checker #(
    parameter int N_LD = 6,
    parameter int N_ST = 3,
    parameter int AW   = 16,
    parameter int TW   = 4,
    localparam int SIW = (N_ST > 1) ? $clog2(N_ST) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ld_req_valid,
    input logic            ld_req_ready,
    input logic            st_req_valid,
    input logic            st_req_ready,
    input logic [N_LD-1:0] ld_busy,
    input logic [SIW:0]    st_count,
    input logic            mem_wr_ack,
    input logic            res_valid,
    input logic            res_grant,
    input logic [TW-1:0]   res_tag,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic            mem_req_write,
    input logic [AW-1:0]   mem_req_addr,
    input logic [TW-1:0]   head_tag
);
    // R2: broadcast tags name a real load slot
    a_r2_tag_range: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_tag != '0 && int'(res_tag) <= N_LD));

    // R4: an accepted load with no free-up occupies one more slot
    a_r4_alloc_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req_valid && ld_req_ready && !(res_valid && res_grant)) |=>
        ($countones(ld_busy) == $past($countones(ld_busy)) + 1));

    // R9: an accepted store with no retire grows the queue by one
    a_r9_queue_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req_valid && st_req_ready && !mem_wr_ack) |=>
        (int'(st_count) == int'($past(st_count)) + 1));

    // R10: a pending write holds its address until accepted
    a_r10_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write && !mem_req_ready) |=>
        (mem_req_valid && mem_req_write && $stable(mem_req_addr)));

    // R6: a write goes out only with its data resolved
    a_r6_write_resolved: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> (head_tag == '0));
endmodule

bind mem_buffer_unit mbu_checker #(.N_LD(N_LD), .N_ST(N_ST), .AW(AW), .TW(TW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ld_req_valid (ld_req_valid),
    .ld_req_ready (ld_req_ready),
    .st_req_valid (st_req_valid),
    .st_req_ready (st_req_ready),
    .ld_busy      (ld_busy),
    .st_count     (st_count),
    .mem_wr_ack   (mem_wr_ack),
    .res_valid    (res_valid),
    .res_grant    (res_grant),
    .res_tag      (res_tag),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write),
    .mem_req_addr (mem_req_addr),
    .head_tag     (st_head_tag)
);

// File: tb/mem_buffer_unit_tb.sv
module mem_buffer_unit_tb;
    localparam int N_LD = 6, N_ST = 3, AW = 16, DW = 32, TW = 4, LIW = 3;

    logic clk = 0, rst_n = 0;
    always #4 clk = ~clk;

    logic ld_req_valid = 0, ld_req_ready;
    logic [AW-1:0] ld_req_addr = 0;
    logic [TW-1:0] ld_issue_tag;
    logic st_req_valid = 0, st_req_ready;
    logic [AW-1:0] st_req_addr = 0;
    logic [DW-1:0] st_req_data = 0;
    logic [TW-1:0] st_req_qtag = 0;
    logic snoop_valid = 0;
    logic [TW-1:0] snoop_tag = 0;
    logic [DW-1:0] snoop_data = 0;
    logic res_valid, res_grant = 1;
    logic [TW-1:0] res_tag;
    logic [DW-1:0] res_data;
    logic mem_req_valid, mem_req_write;
    logic mem_req_ready = 1;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic [LIW-1:0] mem_req_id, mem_rsp_id = 0;
    logic mem_rsp_valid = 0, mem_wr_ack = 0;
    logic [DW-1:0] mem_rsp_data = 0;

    mem_buffer_unit u_dut (.*);

    int vec = 0, bad = 0, cyc = 0;
    logic [DW-1:0] mem [256];
    int pend [N_LD];
    int cnt [N_LD];
    logic [7:0] paddr [N_LD];
    int wack_pend = 0;
    int bc_n = 0;
    logic [TW-1:0] bc_tag [64];
    logic [DW-1:0] bc_data [64];

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                mem[mem_req_addr[7:0]] = mem_req_wdata;
                wack_pend = 1;
            end else begin
                pend[mem_req_id]  = 1;
                paddr[mem_req_id] = mem_req_addr[7:0];
                cnt[mem_req_id]   = (mem_req_addr[7:4] == 4'h8) ? 8 : 1;
            end
        end
        if (res_valid && res_grant && bc_n < 64) begin
            bc_tag[bc_n]  = res_tag;
            bc_data[bc_n] = res_data;
            bc_n++;
        end
    end

    always @(negedge clk) begin
        logic sent;
        sent = 0;
        mem_rsp_valid <= 0;
        mem_wr_ack    <= 0;
        if (wack_pend != 0) begin mem_wr_ack <= 1; wack_pend = 0; end
        for (int i = 0; i < N_LD; i++) begin
            if (pend[i] != 0) begin
                if (cnt[i] <= 1 && !sent) begin
                    mem_rsp_valid <= 1;
                    mem_rsp_id    <= LIW'(i);
                    mem_rsp_data  <= mem[paddr[i]];
                    pend[i] = 0;
                    sent = 1;
                end else if (cnt[i] > 1) cnt[i]--;
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic issue_ld(logic [AW-1:0] a);
        ld_req_valid = 1; ld_req_addr = a;
        tick(1);
        ld_req_valid = 0;
    endtask

    task automatic issue_st(logic [AW-1:0] a, logic [DW-1:0] d, logic [TW-1:0] q);
        st_req_valid = 1; st_req_addr = a; st_req_data = d; st_req_qtag = q;
        tick(1);
        st_req_valid = 0;
    endtask

    task automatic bcast(logic [TW-1:0] t, logic [DW-1:0] d);
        snoop_valid = 1; snoop_tag = t; snoop_data = d;
        tick(1);
        snoop_valid = 0;
    endtask

    task automatic wait_bc(int target);
        for (int k = 0; k < 300 && bc_n < target; k++) tick(1);
    endtask

    task automatic t_reset;
        chk("R1 ld_ready", ld_req_ready, 1);
        chk("R1 st_ready", st_req_ready, 1);
        chk("R1 mem_req_valid", mem_req_valid, 0);
        chk("R1 res_valid", res_valid, 0);
    endtask

    task automatic t_load_hit;
        int b = bc_n;
        mem[8'h10] = 32'hA0A0_0010;
        chk("R2 issue tag", ld_issue_tag, 1);
        issue_ld(16'h0010);
        wait_bc(b + 1);
        chk("R2 bc tag", bc_tag[b], 1);
        chk("R2 bc data", bc_data[b], 32'hA0A0_0010);
    endtask

    task automatic t_out_of_order;
        int b = bc_n;
        mem[8'h80] = 32'hB000_0080;
        mem[8'h11] = 32'hC000_0011;
        issue_ld(16'h0080);
        issue_ld(16'h0011);
        wait_bc(b + 2);
        chk("R3 first tag", bc_tag[b], 2);
        chk("R3 first data", bc_data[b], 32'hC000_0011);
        chk("R3 second tag", bc_tag[b+1], 1);
        chk("R3 second data", bc_data[b+1], 32'hB000_0080);
    endtask

    task automatic t_full_loads;
        int b = bc_n;
        for (int i = 0; i < N_LD; i++) issue_ld(16'h0080 + 16'(i));
        chk("R4 ld_ready low", ld_req_ready, 0);
        issue_ld(16'h0020);
        wait_bc(b + N_LD);
        tick(15);
        chk("R4 extra ignored", 64'(bc_n - b), 64'(N_LD));
        chk("R4 ld_ready back", ld_req_ready, 1);
    endtask

    task automatic t_store_ready;
        mem[8'h30] = 0;
        issue_st(16'h0030, 32'hD000_0030, 0);
        tick(5);
        chk("R5 mem written", mem[8'h30], 32'hD000_0030);
        chk("R5 st_ready", st_req_ready, 1);
    endtask

    task automatic t_store_wait;
        mem[8'h31] = 32'h1111_1111;
        issue_st(16'h0031, 32'hDEAD_0000, 5);
        tick(6);
        chk("R6 no early write", mem[8'h31], 32'h1111_1111);
        bcast(7, 32'h7777_7777);
        tick(4);
        chk("R7 other tag ignored", mem[8'h31], 32'h1111_1111);
        bcast(5, 32'h5555_0031);
        tick(4);
        chk("R6 captured write", mem[8'h31], 32'h5555_0031);
    endtask

    task automatic t_hold;
        int b = bc_n;
        mem[8'h40] = 32'h0000_0040;
        mem[8'h41] = 32'h4141_4141;
        issue_st(16'h0040, 0, 3);
        issue_ld(16'h0040);
        tick(10);
        chk("R8 held load silent", 64'(bc_n - b), 0);
        issue_ld(16'h0041);
        wait_bc(b + 1);
        chk("R8 other addr not held", bc_data[b], 32'h4141_4141);
        bcast(3, 32'h3333_0040);
        wait_bc(b + 2);
        chk("R8 held load tag", bc_tag[b+1], 1);
        chk("R8 held load sees store", bc_data[b+1], 32'h3333_0040);
    endtask

    task automatic t_store_order;
        mem[8'h50] = 0; mem[8'h52] = 0;
        issue_st(16'h0050, 0, 4);
        issue_st(16'h0050, 0, 5);
        issue_st(16'h0052, 32'hEEEE_0052, 0);
        chk("R9 st_ready low", st_req_ready, 0);
        tick(5);
        chk("R10 young waits", mem[8'h52], 0);
        bcast(5, 32'h5050_0005);
        tick(3);
        chk("R10 still blocked", mem[8'h50], 0);
        bcast(4, 32'h5050_0004);
        tick(12);
        chk("R10 in-order final", mem[8'h50], 32'h5050_0005);
        chk("R10 young written", mem[8'h52], 32'hEEEE_0052);
    endtask

    task automatic t_same_cycle;
        mem[8'h60] = 0;
        st_req_valid = 1; st_req_addr = 16'h0060; st_req_data = 32'hBAD0_0000; st_req_qtag = 6;
        snoop_valid = 1; snoop_tag = 6; snoop_data = 32'h6666_0060;
        tick(1);
        st_req_valid = 0; snoop_valid = 0;
        tick(6);
        chk("R11 same-cycle capture", mem[8'h60], 32'h6666_0060);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'(i) * 32'h0101_0101;
        for (int i = 0; i < N_LD; i++) begin pend[i] = 0; cnt[i] = 0; paddr[i] = 0; end
        tick(3);
        rst_n = 1;
        tick(1);
        t_reset;
        t_load_hit;
        t_out_of_order;
        t_full_loads;
        t_store_ready;
        t_store_wait;
        t_hold;
        t_store_order;
        t_same_cycle;
        $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    always @(negedge clk) begin
        if (cyc > 20000) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end
endmodule